// File: doc/BRIEF.md
# Command-Driven Processor Status Register

This block holds the run-control flags of a small processor and changes them only through 32-bit command words. A command word does not carry the new flag values. Each flag that can be controlled has one bit that asks for it to be set and another bit that asks for it to be cleared. Software can therefore touch any subset of flags in one write and leave the others alone. If a write raises both request bits of the same flag, the two requests cancel and the flag keeps its value. The flags are halt, single-step, interrupt-on-break and eight general signal flags. A broke flag is set by an external break event, and commands can only clear it. The interrupt command pair does not change a stored status bit. It drives an interrupt request line that goes to an external interrupt controller.

The register is read through a 32-bit word that changes with the stored flags. That word also contains a DMA-busy bit, which another unit drives and which commands cannot write. When a command moves halt from 0 to 1, the block produces a one-cycle halt-request pulse for the processor core. Control and status pins are plain level signals. There is no data stream and no handshake at the block's edge.

Top module: `sc_status_reg`

## Requirements
- R1: When a write sets exactly one bit of a pair, the flag of that pair is set or cleared. The pairs are clear/set at bits 0/1 for halt, 5/6 for single-step and 7/8 for interrupt-on-break. Signal flag i uses bit 9+2i to clear it and bit 10+2i to set it.
- R2: When a write sets both bits of a pair, that flag keeps its previous value.
- R3: The read word puts halt at bit 0, broke at bit 1, DMA busy at bit 2, single-step at bit 5, interrupt-on-break at bit 6 and signal flag i at bit 7+i. Every other bit reads 0.
- R4: A cycle with `break_evt` high sets broke. Command bit 2 clears broke. If both happen in the same cycle, broke ends up set.
- R5: Command bit 4 alone asserts `irq_req`, and command bit 3 alone deasserts it. When both bits are written, the line does not change.
- R6: A set-halt command without clear-halt makes `halt_pulse` high for exactly the one cycle after the write. This happens only if halt was 0 before the write. A set-halt command when halt is already 1 gives no pulse.
- R7: The DMA-busy bit of the read word follows `dma_busy_in` combinationally, and no command can change it.
- R8: After reset, halt is 1, every other stored flag is 0, `irq_req` is 0 and `halt_pulse` is 0.
- R9: A command takes effect at the clock edge where `wr_en` is high, and the new state is visible right after that edge. While `wr_en` is low, `wr_data` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 32 | Command word |
| break_evt | input | 1 | External break event, sets broke |
| dma_busy_in | input | 1 | DMA-busy status from the DMA engine |
| rd_data | output | 32 | Status read word |
| irq_req | output | 1 | Interrupt request line |
| halt_pulse | output | 1 | One-cycle halt request |

## Verification
The hardest cases to reach are same-cycle conflicts: a clear-broke command in the same cycle as a break event, and a write that sets both bits of a pair on a flag already holding the value that could change. The directed stimulus first forces each flag into the state that a one-sided command would alter. It then issues the conflicting write and reads the word back on the next cycle. The halt pulse is checked twice: on a true 0-to-1 transition, and on a repeated set-halt command while halt is already 1.

// File: rtl/sc_status_pkg.sv
package sc_status_pkg;
  localparam int WORD_W      = 32;
  localparam int SIG_COUNT   = 8;
  // command word bit positions
  localparam int CMD_HALT_CLR = 0;
  localparam int CMD_HALT_SET = 1;
  localparam int CMD_BRK_CLR  = 2;
  localparam int CMD_IRQ_CLR  = 3;
  localparam int CMD_IRQ_SET  = 4;
  localparam int CMD_SS_CLR   = 5;
  localparam int CMD_SS_SET   = 6;
  localparam int CMD_IB_CLR   = 7;
  localparam int CMD_IB_SET   = 8;
  localparam int CMD_SIG_BASE = 9;
  localparam int CMD_USED     = CMD_SIG_BASE + 2 * SIG_COUNT;
  // read word bit positions
  localparam int RD_HALT     = 0;
  localparam int RD_BRK      = 1;
  localparam int RD_DMA      = 2;
  localparam int RD_SS       = 5;
  localparam int RD_IB       = 6;
  localparam int RD_SIG_BASE = 7;

  typedef struct packed {
    logic                 halt;
    logic                 broke;
    logic                 sstep;
    logic                 int_brk;
    logic [SIG_COUNT-1:0] sig;
  } status_t;
endpackage

// File: rtl/sc_pair_flag.sv
module sc_pair_flag #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic set_cmd,
  input  logic clr_cmd,
  output logic q
);
  logic set_only, clr_only;
  assign set_only = wr_en && set_cmd && !clr_cmd;
  assign clr_only = wr_en && clr_cmd && !set_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n)        q <= RESET_VAL;
    else if (set_only) q <= 1'b1;
    else if (clr_only) q <= 1'b0;
  end

  p_set_alone_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && set_cmd && !clr_cmd) |=> q);
  p_clr_alone_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && clr_cmd && !set_cmd) |=> !q);
  p_both_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && set_cmd && clr_cmd) |=> $stable(q));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/sc_halt_ctl.sv
module sc_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic set_cmd,
  input  logic clr_cmd,
  output logic halt,
  output logic halt_pulse
);
  sc_pair_flag #(.RESET_VAL(1'b1)) u_flag (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .set_cmd(set_cmd), .clr_cmd(clr_cmd), .q(halt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) halt_pulse <= 1'b0;
    else        halt_pulse <= wr_en && set_cmd && !clr_cmd && !halt;
  end

  p_pulse_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pulse |-> (halt && !$past(halt)));
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pulse |=> !halt_pulse);
endmodule

// File: rtl/sc_status_pack.sv
module sc_status_pack
  import sc_status_pkg::*;
(
  input  status_t             st,
  input  logic                dma_busy,
  output logic [WORD_W-1:0]   word
);
  always_comb begin
    word          = '0;
    word[RD_HALT] = st.halt;
    word[RD_BRK]  = st.broke;
    word[RD_DMA]  = dma_busy;
    word[RD_SS]   = st.sstep;
    word[RD_IB]   = st.int_brk;
    word[RD_SIG_BASE +: SIG_COUNT] = st.sig;
  end
endmodule

// File: rtl/sc_status_reg.sv
module sc_status_reg
  import sc_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              break_evt,
  input  logic              dma_busy_in,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq_req,
  output logic              halt_pulse
);
  status_t st;
  logic    unused_hi;
  assign unused_hi = ^wr_data[WORD_W-1:CMD_USED];

  sc_halt_ctl u_halt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .set_cmd(wr_data[CMD_HALT_SET]), .clr_cmd(wr_data[CMD_HALT_CLR]),
    .halt(st.halt), .halt_pulse(halt_pulse)
  );

  sc_pair_flag u_sstep (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .set_cmd(wr_data[CMD_SS_SET]), .clr_cmd(wr_data[CMD_SS_CLR]), .q(st.sstep)
  );

  sc_pair_flag u_intbrk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .set_cmd(wr_data[CMD_IB_SET]), .clr_cmd(wr_data[CMD_IB_CLR]), .q(st.int_brk)
  );

  sc_pair_flag u_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .set_cmd(wr_data[CMD_IRQ_SET]), .clr_cmd(wr_data[CMD_IRQ_CLR]), .q(irq_req)
  );

  for (genvar i = 0; i < SIG_COUNT; i++) begin : g_sig
    sc_pair_flag u_sig (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .set_cmd(wr_data[CMD_SIG_BASE + 2*i + 1]),
      .clr_cmd(wr_data[CMD_SIG_BASE + 2*i]),
      .q(st.sig[i])
    );
  end

  // broke: event-only set, command-only clear, event wins a tie
  always_ff @(posedge clk) begin
    if (!rst_n)                          st.broke <= 1'b0;
    else if (break_evt)                  st.broke <= 1'b1;
    else if (wr_en && wr_data[CMD_BRK_CLR]) st.broke <= 1'b0;
  end

  sc_status_pack u_pack (.st(st), .dma_busy(dma_busy_in), .word(rd_data));

  p_break_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    break_evt |=> rd_data[RD_BRK]);
  p_brk_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CMD_BRK_CLR] && !break_evt) |=> !rd_data[RD_BRK]);
  p_dma_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[RD_DMA] == dma_busy_in);
  p_zero_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4:3] == 2'b00 && rd_data[WORD_W-1:RD_SIG_BASE+SIG_COUNT] == '0);
endmodule

// File: tb/sc_status_reg_test.sv
module sc_status_reg_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        break_evt = 1'b0;
  logic        dma_busy_in = 1'b0;
  logic [31:0] rd_data;
  logic        irq_req, halt_pulse;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_status_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .break_evt(break_evt), .dma_busy_in(dma_busy_in),
    .rd_data(rd_data), .irq_req(irq_req), .halt_pulse(halt_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one command for one edge, return at the following negedge
  task automatic cmd(input logic [31:0] d, input logic brk = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; break_evt = brk;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; break_evt = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 read word", rd_data, 32'h1);
    chk("R8 irq", {31'b0, irq_req}, 32'h0);
    chk("R8 pulse", {31'b0, halt_pulse}, 32'h0);
  endtask

  task automatic t_halt();
    cmd(32'h1);
    chk("R1 clear halt", rd_data, 32'h0);
    cmd(32'h2);
    chk("R1 set halt", rd_data, 32'h1);
    chk("R6 pulse on rise", {31'b0, halt_pulse}, 32'h1);
    @(negedge clk);
    chk("R6 pulse one cycle", {31'b0, halt_pulse}, 32'h0);
    cmd(32'h2);
    chk("R6 no pulse when halted", {31'b0, halt_pulse}, 32'h0);
    cmd(32'h3);
    chk("R2 halt both held 1", rd_data, 32'h1);
    cmd(32'h1);
    cmd(32'h3);
    chk("R2 halt both held 0", rd_data, 32'h0);
    chk("R6 no pulse on both", {31'b0, halt_pulse}, 32'h0);
    cmd(32'h2);
  endtask

  task automatic t_flags();
    logic [31:0] exp = 32'h1;
    cmd(32'h1 << 6);
    exp |= 32'h1 << 5;
    chk("R1 set single-step", rd_data, exp);
    cmd(32'h1 << 8);
    exp |= 32'h1 << 6;
    chk("R1 set int-on-break", rd_data, exp);
    for (int i = 0; i < 8; i++) begin
      cmd(32'h1 << (10 + 2*i));
      exp |= 32'h1 << (7 + i);
      chk($sformatf("R1 R3 set signal %0d", i), rd_data, exp);
    end
    cmd(32'h3 << 15);
    chk("R2 signal 3 both held", rd_data, exp);
    // idle cycle with a command on the bus but no strobe
    @(negedge clk);
    wr_data = 32'h1 << 5;
    @(negedge clk);
    wr_data = '0;
    chk("R9 no strobe no change", rd_data, exp);
    begin
      logic [31:0] clrs = (32'h1 << 5) | (32'h1 << 7);
      for (int i = 0; i < 8; i++) clrs |= 32'h1 << (9 + 2*i);
      cmd(clrs);
    end
    chk("R1 clear all flags", rd_data, 32'h1);
  endtask

  task automatic t_broke();
    @(negedge clk);
    break_evt = 1'b1;
    @(negedge clk);
    break_evt = 1'b0;
    chk("R4 break sets broke", rd_data, 32'h3);
    cmd(32'h4, 1'b1);
    chk("R4 event wins over clear", rd_data, 32'h3);
    cmd(32'h4);
    chk("R4 clear broke", rd_data, 32'h1);
  endtask

  task automatic t_irq();
    cmd(32'h1 << 4);
    chk("R5 irq set", {31'b0, irq_req}, 32'h1);
    chk("R3 irq not in word", rd_data, 32'h1);
    cmd(32'h3 << 3);
    chk("R5 irq both held 1", {31'b0, irq_req}, 32'h1);
    cmd(32'h1 << 3);
    chk("R5 irq clear", {31'b0, irq_req}, 32'h0);
    cmd(32'h3 << 3);
    chk("R5 irq both held 0", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_dma();
    @(negedge clk);
    dma_busy_in = 1'b1;
    #1;
    chk("R7 dma busy visible", rd_data, 32'h5);
    cmd(32'hFFFF_FFFF);
    chk("R7 R2 all-ones write", rd_data, 32'h5);
    chk("R7 pulse quiet", {31'b0, halt_pulse}, 32'h0);
    dma_busy_in = 1'b0;
    #1;
    chk("R7 dma busy drop", rd_data, 32'h1);
  endtask

  initial begin
    t_reset();
    t_halt();
    t_flags();
    t_broke();
    t_irq();
    t_dma();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule